// File: doc/BRIEF.md
# Iterative Multiply and Divide Unit

This block multiplies two 8-bit unsigned operands by shift-and-add and divides a 16-bit unsigned dividend by an 8-bit unsigned divisor by restoring division. Both operations run in the same three registers: an accumulator that holds the growing product or the shrinking remainder, a quotient register that holds the multiplier or collects quotient bits, and a wide shifting operand register. One step is taken per clock, so a multiply needs 8 cycles and a divide needs 16.

A one-cycle start pulse loads the operands and starts the step counter of the requested operation. The accumulator and the quotient register drive the outputs directly at all times. A reader can therefore see partial results during an operation, and the exact value seen depends on how many steps have run. A new start pulse abandons any operation in progress.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `acc_o` and `quo_o` are 0 and `busy_o` is low.
- R2: On the clock edge that samples `mul_start_i`, `acc_o` becomes 0, `quo_o` becomes the zero-extended `mplier_i`, and `busy_o` goes high.
- R3: A multiply takes one step per clock. After k steps (k ≤ 8), `acc_o` = `mcand_i` × (`mplier_i` mod 2^k) and `quo_o` = `mplier_i` >> k. After 8 steps, `acc_o` holds the full product and `quo_o` is 0.
- R4: On the clock edge that samples `div_start_i`, `acc_o` becomes `dividend_i`, `quo_o` becomes 0, and `busy_o` goes high.
- R5: A divide takes one step per clock. After k steps (k ≤ 16), with D = `divisor_i` × 2^(16−k), `quo_o` = floor(`dividend_i` / D) and `acc_o` = `dividend_i` − `quo_o` × D. After 16 steps, these are the quotient and the remainder.
- R6: If the divisor is 0, each divide step sets the new quotient bit. After k steps `quo_o` is 2^k − 1, and `acc_o` keeps the dividend throughout.
- R7: `busy_o` stays high for exactly 8 clocks after a multiply load and exactly 16 clocks after a divide load. It then goes low.
- R8: While `busy_o` is low and no start is sampled, `acc_o` and `quo_o` hold their values, even if the operand inputs change.
- R9: A start sampled while an operation is running abandons that operation. The new operation loads and runs its full number of steps from its own operands.
- R10: If `mul_start_i` and `div_start_i` are sampled high in the same cycle, the multiply is loaded and the divide request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mul_start_i | input | 1 | Load multiply operands and start |
| mcand_i | input | 8 | Multiplicand |
| mplier_i | input | 8 | Multiplier |
| div_start_i | input | 1 | Load divide operands and start |
| dividend_i | input | 16 | Dividend |
| divisor_i | input | 8 | Divisor |
| acc_o | output | 16 | Product, or remainder (partial during operation) |
| quo_o | output | 16 | Remaining multiplier bits, or quotient (partial during operation) |
| busy_o | output | 1 | Operation in progress |

## Verification
The hardest case to reach is an operation interrupted partway through, where the intermediate register contents must match the closed-form expressions for a given step count. The bench queues one expected item for every cycle after a load, so every partial value is compared, not only the final one. It also fires a divide load four cycles into a multiply, so the abandoned state must be fully overwritten. A zero divisor and a simultaneous dual start push the step logic into its saturating and priority paths.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_MUL  = 2'd1,
    OP_DIV  = 2'd2
  } muldiv_op_e;
endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int MUL_STEPS = 8,
  parameter int DIV_STEPS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mul_start_i,
  input  logic       div_start_i,
  output muldiv_op_e load_o,
  output muldiv_op_e step_o,
  output logic       busy_o
);
  localparam int MAX_STEPS = (MUL_STEPS > DIV_STEPS) ? MUL_STEPS : DIV_STEPS;
  localparam int CNT_W     = $clog2(MAX_STEPS + 1);

  logic [CNT_W-1:0] mul_cnt_q, div_cnt_q;
  logic             mul_run, div_run;

  assign mul_run = (mul_cnt_q != '0);
  assign div_run = (div_cnt_q != '0);
  assign busy_o  = mul_run | div_run;

  // multiply wins a simultaneous request
  always_comb begin
    if (mul_start_i)      load_o = OP_MUL;
    else if (div_start_i) load_o = OP_DIV;
    else                  load_o = OP_NONE;
  end

  always_comb begin
    step_o = OP_NONE;
    if (load_o == OP_NONE) begin
      if (mul_run)      step_o = OP_MUL;
      else if (div_run) step_o = OP_DIV;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mul_cnt_q <= '0;
      div_cnt_q <= '0;
    end else begin
      unique case (load_o)
        OP_MUL: begin
          mul_cnt_q <= CNT_W'(MUL_STEPS);
          div_cnt_q <= '0;
        end
        OP_DIV: begin
          mul_cnt_q <= '0;
          div_cnt_q <= CNT_W'(DIV_STEPS);
        end
        default: begin
          if (mul_run) mul_cnt_q <= mul_cnt_q - 1'b1;
          if (div_run) div_cnt_q <= div_cnt_q - 1'b1;
        end
      endcase
    end
  end

  // R7
  mul_cnt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mul_start_i && !div_start_i && mul_run) |=> (mul_cnt_q == $past(mul_cnt_q) - 1'b1));

  // R7
  div_cnt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mul_start_i && !div_start_i && div_run) |=> (div_cnt_q == $past(div_cnt_q) - 1'b1));

  // R9
  single_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mul_run && div_run));

  // R10
  mul_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mul_start_i && div_start_i) |=> (mul_run && !div_run));
endmodule

// File: rtl/muldiv_mul_step.sv
module muldiv_mul_step #(
  parameter int ACC_W = 16,
  parameter int SH_W  = 24
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [ACC_W-1:0] quo_i,
  input  logic [SH_W-1:0]  sh_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [ACC_W-1:0] quo_o,
  output logic [SH_W-1:0]  sh_o
);
  logic [SH_W-1:0] sum;

  assign sum   = SH_W'(acc_i) + sh_i;
  assign acc_o = quo_i[0] ? sum[ACC_W-1:0] : acc_i;
  assign quo_o = quo_i >> 1;
  assign sh_o  = sh_i << 1;

  logic unused_hi;
  assign unused_hi = ^sum[SH_W-1:ACC_W];
endmodule

// File: rtl/muldiv_div_step.sv
module muldiv_div_step #(
  parameter int ACC_W = 16,
  parameter int SH_W  = 24
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [ACC_W-1:0] quo_i,
  input  logic [SH_W-1:0]  sh_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [ACC_W-1:0] quo_o,
  output logic [SH_W-1:0]  sh_o
);
  logic [SH_W-1:0] acc_ext, diff;
  logic            fits;

  assign sh_o    = sh_i >> 1;
  assign acc_ext = SH_W'(acc_i);
  assign fits    = (acc_ext >= sh_o);
  assign diff    = acc_ext - sh_o;
  assign acc_o   = fits ? diff[ACC_W-1:0] : acc_i;
  assign quo_o   = {quo_i[ACC_W-2:0], fits};

  logic unused_hi;
  assign unused_hi = ^diff[SH_W-1:ACC_W];
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int OP_W  = 8,
  parameter int ACC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mul_start_i,
  input  logic [OP_W-1:0]  mcand_i,
  input  logic [OP_W-1:0]  mplier_i,
  input  logic             div_start_i,
  input  logic [ACC_W-1:0] dividend_i,
  input  logic [OP_W-1:0]  divisor_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [ACC_W-1:0] quo_o,
  output logic             busy_o
);
  localparam int SH_W = OP_W + ACC_W;

  muldiv_op_e       load_op, step_op;
  logic [ACC_W-1:0] acc_q, quo_q;
  logic [SH_W-1:0]  sh_q;
  logic [ACC_W-1:0] m_acc, m_quo, d_acc, d_quo;
  logic [SH_W-1:0]  m_sh, d_sh;

  muldiv_ctrl #(
    .MUL_STEPS(OP_W),
    .DIV_STEPS(ACC_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mul_start_i(mul_start_i),
    .div_start_i(div_start_i),
    .load_o     (load_op),
    .step_o     (step_op),
    .busy_o     (busy_o)
  );

  muldiv_mul_step #(.ACC_W(ACC_W), .SH_W(SH_W)) u_mul (
    .acc_i(acc_q), .quo_i(quo_q), .sh_i(sh_q),
    .acc_o(m_acc), .quo_o(m_quo), .sh_o(m_sh)
  );

  muldiv_div_step #(.ACC_W(ACC_W), .SH_W(SH_W)) u_div (
    .acc_i(acc_q), .quo_i(quo_q), .sh_i(sh_q),
    .acc_o(d_acc), .quo_o(d_quo), .sh_o(d_sh)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      quo_q <= '0;
      sh_q  <= '0;
    end else if (load_op == OP_MUL) begin
      acc_q <= '0;
      quo_q <= ACC_W'(mplier_i);
      sh_q  <= SH_W'(mcand_i);
    end else if (load_op == OP_DIV) begin
      acc_q <= dividend_i;
      quo_q <= '0;
      sh_q  <= {divisor_i, {ACC_W{1'b0}}};
    end else if (step_op == OP_MUL) begin
      acc_q <= m_acc;
      quo_q <= m_quo;
      sh_q  <= m_sh;
    end else if (step_op == OP_DIV) begin
      acc_q <= d_acc;
      quo_q <= d_quo;
      sh_q  <= d_sh;
    end
  end

  assign acc_o = acc_q;
  assign quo_o = quo_q;

  // R2
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mul_start_i || div_start_i) |=> busy_o);

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !mul_start_i && !div_start_i) |=> ($stable(acc_o) && $stable(quo_o)));

  // R3
  mul_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_op == OP_MUL && !quo_q[0]) |=> $stable(acc_q));

  // R5
  rem_shrink_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_op == OP_DIV) |=> (acc_q <= $past(acc_q)));
endmodule

// File: tb/muldiv_unit_tb_top.sv
module muldiv_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] acc;
    logic [15:0] quo;
    logic        busy;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mul_start = 1'b0, div_start = 1'b0;
  logic [7:0]  mcand = '0, mplier = '0, divisor = '0;
  logic [15:0] dividend = '0;
  logic [15:0] acc, quo;
  logic        busy;

  int   n_vec = 0, n_err = 0;
  exp_t exp_q[$];
  exp_t last_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  muldiv_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .mul_start_i(mul_start), .mcand_i(mcand), .mplier_i(mplier),
    .div_start_i(div_start), .dividend_i(dividend), .divisor_i(divisor),
    .acc_o(acc), .quo_o(quo), .busy_o(busy)
  );

  function automatic exp_t mul_exp(input logic [7:0] mc, input logic [7:0] mp, input int k, input string tag);
    exp_t e;
    int kk = (k > 8) ? 8 : k;
    e.acc  = 16'(int'(mc) * (int'(mp) % (1 << kk)));
    e.quo  = 16'(int'(mp) >> kk);
    e.busy = (k < 8);
    e.tag  = tag;
    return e;
  endfunction

  function automatic exp_t div_exp(input logic [15:0] dd, input logic [7:0] dv, input int k, input string tag);
    exp_t e;
    int kk = (k > 16) ? 16 : k;
    if (dv == 0) begin
      e.quo = 16'((1 << kk) - 1);
      e.acc = dd;
    end else begin
      int d = int'(dv) << (16 - kk);
      int q = int'(dd) / d;
      e.quo = 16'(q);
      e.acc = 16'(int'(dd) - q * d);
    end
    e.busy = (k < 16);
    e.tag  = tag;
    return e;
  endfunction

  task automatic compare(input exp_t e);
    n_vec++;
    if (acc !== e.acc || quo !== e.quo || busy !== e.busy) begin
      n_err++;
      $display("FAIL %s: acc=%h quo=%h busy=%b expected acc=%h quo=%h busy=%b",
               e.tag, acc, quo, busy, e.acc, e.quo, e.busy);
    end
  endtask

  // monitor
  initial forever begin
    @(negedge clk);
    #1;
    if (exp_q.size() > 0) compare(exp_q.pop_front());
  end

  task automatic run_op(input bit m, input bit d, input logic [7:0] mc, input logic [7:0] mp,
                        input logic [15:0] dd, input logic [7:0] dv, input int n_items, input string tag);
    @(negedge clk);
    mul_start = m; div_start = d;
    mcand = mc; mplier = mp; dividend = dd; divisor = dv;
    @(negedge clk);
    mul_start = 1'b0; div_start = 1'b0;
    for (int k = 0; k < n_items; k++) begin
      last_exp = m ? mul_exp(mc, mp, k, tag) : div_exp(dd, dv, k, tag);
      exp_q.push_back(last_exp);
    end
    repeat (n_items - 1) @(negedge clk);
  endtask

  task automatic idle_poke(input string tag);
    exp_t e = last_exp;
    e.tag = tag;
    @(negedge clk);
    mcand = 8'hA5; mplier = 8'h3C; dividend = 16'h1234; divisor = 8'h07;
    @(negedge clk);
    for (int k = 0; k < 4; k++) exp_q.push_back(e);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    begin
      exp_t e;
      e.acc = '0; e.quo = '0; e.busy = 1'b0; e.tag = "R1 reset";
      compare(e);
    end
    rst_n = 1'b1;
    // R2 R3 R7 R8: full multiply, partial values and idle after
    run_op(1, 0, 8'd13, 8'd11, '0, '0, 11, "R3 mul 13x11");
    run_op(1, 0, 8'd255, 8'd255, '0, '0, 11, "R3 mul 255x255");
    run_op(1, 0, 8'd0, 8'hB7, '0, '0, 10, "R2 mul 0 mcand");
    // R4 R5 R7
    run_op(0, 1, '0, '0, 16'd1000, 8'd7, 19, "R5 div 1000/7");
    run_op(0, 1, '0, '0, 16'hFFFF, 8'd1, 18, "R5 div ffff/1");
    run_op(0, 1, '0, '0, 16'hFFFF, 8'd255, 18, "R5 div ffff/255");
    run_op(0, 1, '0, '0, 16'd5, 8'd200, 18, "R4 div small dividend");
    // R6
    run_op(0, 1, '0, '0, 16'hBEEF, 8'd0, 18, "R6 div by zero");
    // R8: operand changes while idle
    idle_poke("R8 idle hold");
    // R9: divide load four cycles into a multiply
    run_op(1, 0, 8'd99, 8'hFF, '0, '0, 4, "R9 mul before restart");
    run_op(0, 1, '0, '0, 16'd54321, 8'd123, 18, "R9 div after restart");
    run_op(0, 1, '0, '0, 16'd40000, 8'd3, 6, "R9 div before restart");
    run_op(1, 0, 8'd17, 8'd201, '0, '0, 10, "R9 mul after restart");
    // R10
    run_op(1, 1, 8'd45, 8'd6, 16'd777, 8'd9, 10, "R10 dual start");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule